// File: doc/BRIEF.md
# Programmable asynchronous serial receiver

This block turns an idle-high asynchronous serial line into parallel characters. It runs from a receive clock at sixteen times the bit rate, so the start bit may arrive at any phase of that clock. A falling edge on the line opens a candidate start bit. The block confirms it near the middle of that bit, then takes one sample at the centre of each data, parity and stop bit. The finished character moves into a holding register, together with its parity-error and framing-error verdicts.

The frame format is not taken from live pins. Word length, parity enable, parity sense and stop count sit on configuration inputs, and the block copies them into an internal control register only while a load strobe is high. The host reads `data_out` and the flags. It then pulses `rdy_clr` to drop `data_ready`. If the host has not done that when the next character lands, the overrun flag reports it.

Top module: `async_char_rx`

## Requirements
- R1: `rst` (active high) returns the receiver to idle. It clears `data_out`, `data_ready`, `overrun_err`, `frame_err` and `parity_err` to 0. It sets the control register to 8 data bits, parity inhibited and one stop bit.
- R2: A low level on `rx_in` seen at a clock edge while idle opens a start bit. The start is accepted only if `rx_in` is still low at the eighth edge, counting the first edge that saw it low. A pulse of seven or fewer clocks low is ignored and produces no character.
- R3: Data bits arrive least significant first, each sampled once, 16 clocks after the previous sample. Word length code `cfg_len` selects 5 (0), 6 (1), 7 (2) or 8 (3) data bits. Unused high bits of `data_out` read 0.
- R4: When `cfg_par_off` is 0, one parity bit follows the data. `cfg_par_even`=1 expects an even count of ones over data plus parity, and 0 expects an odd count. A mismatch sets `parity_err` for that character. When parity is inhibited, `parity_err` is 0.
- R5: `cfg_two_stop`=1 samples two stop bits and 0 samples one. `frame_err` is set if any sampled stop bit is low. The character is transferred at the centre of the last stop bit, so with two stops `data_ready` is still 0 at the end of the first stop bit.
- R6: Format inputs take effect only through the control register, captured on clock edges where `cfg_load` is 1. Changing them without the strobe does not change how the next character is received.
- R7: On transfer, `data_out` takes the character and `data_ready` rises. `frame_err` and `parity_err` take that character's verdicts and hold them, even across `rdy_clr`, until the next transfer.
- R8: `rdy_clr` high at a clock edge with no transfer clears `data_ready`. `data_ready` never falls without it.
- R9: On transfer, `overrun_err` becomes 1 if `data_ready` was still 1 and `rdy_clr` was not high at that edge, and 0 otherwise. A clear in the transfer cycle counts as a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, 16x bit rate |
| rst | input | 1 | Master reset, active high |
| rx_in | input | 1 | Serial line, idle high |
| cfg_load | input | 1 | Control register load strobe |
| cfg_len | input | 2 | Word length code (0..3 = 5..8 bits) |
| cfg_par_off | input | 1 | 1 = no parity bit |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| rdy_clr | input | 1 | Clears data_ready |
| data_out | output | 8 | Holding register |
| data_ready | output | 1 | Character available |
| overrun_err | output | 1 | Previous character not read |
| frame_err | output | 1 | Stop bit sampled low |
| parity_err | output | 1 | Parity mismatch |

## Verification
Two events can land on the same clock edge: a character moving into the holding register, and the host clearing `data_ready`. The bench times `rdy_clr` to be high for only the edge at the centre of the last stop bit, while an earlier character is still unread. It expects `data_ready` to stay 1 with `overrun_err` at 0. A transfer with no clear at all, over an unread character, must instead raise `overrun_err`, which separates the two outcomes.

// File: rtl/async_char_rx.sv
module async_char_rx #(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_in,
  input  logic              cfg_load,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_par_off,
  input  logic              cfg_par_even,
  input  logic              cfg_two_stop,
  input  logic              rdy_clr,
  output logic [DATA_W-1:0] data_out,
  output logic              data_ready,
  output logic              overrun_err,
  output logic              frame_err,
  output logic              parity_err
);

  localparam int CW     = $clog2(OVERSAMPLE);
  localparam int IW     = $clog2(DATA_W);
  localparam int MID    = OVERSAMPLE / 2;
  localparam int MINLEN = DATA_W - 3;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP1, S_STOP2} st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic [IW-1:0]    idx;
  logic [DATA_W-1:0] sh;
  logic             pe_pend, fe_pend;

  logic [1:0]       len_q;
  logic             poff_q, even_q, two_q;

  logic             tick, last_bit, xfer, fe_now;
  logic [IW-1:0]    last_idx;

  assign tick     = (cnt == CW'(OVERSAMPLE - 1));
  assign last_idx = IW'(MINLEN - 1) + IW'(len_q);
  assign last_bit = (idx == last_idx);
  assign xfer     = tick && ((st == S_STOP1 && !two_q) || st == S_STOP2);
  assign fe_now   = !rx_in || (st == S_STOP2 && fe_pend);

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q  <= 2'd3;
      poff_q <= 1'b1;
      even_q <= 1'b0;
      two_q  <= 1'b0;
    end else if (cfg_load) begin
      len_q  <= cfg_len;
      poff_q <= cfg_par_off;
      even_q <= cfg_par_even;
      two_q  <= cfg_two_stop;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      cnt     <= '0;
      idx     <= '0;
      sh      <= '0;
      pe_pend <= 1'b0;
      fe_pend <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (!rx_in) begin
            st  <= S_START;
            cnt <= CW'(1);
          end
        end
        S_START: begin
          if (cnt == CW'(MID - 1)) begin
            if (!rx_in) begin
              st      <= S_DATA;
              cnt     <= '0;
              idx     <= '0;
              sh      <= '0;
              pe_pend <= 1'b0;
              fe_pend <= 1'b0;
            end else begin
              st <= S_IDLE;
            end
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        S_DATA: begin
          if (tick) begin
            sh[idx] <= rx_in;
            cnt     <= '0;
            idx     <= idx + IW'(1);
            if (last_bit) st <= poff_q ? S_STOP1 : S_PAR;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        S_PAR: begin
          if (tick) begin
            pe_pend <= (^sh) ^ rx_in ^ !even_q;
            cnt     <= '0;
            st      <= S_STOP1;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        S_STOP1: begin
          if (tick) begin
            cnt <= '0;
            if (two_q) begin
              fe_pend <= !rx_in;
              st      <= S_STOP2;
            end else begin
              st <= S_IDLE;
            end
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        S_STOP2: begin
          if (tick) begin
            cnt <= '0;
            st  <= S_IDLE;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_out    <= '0;
      data_ready  <= 1'b0;
      overrun_err <= 1'b0;
      frame_err   <= 1'b0;
      parity_err  <= 1'b0;
    end else if (xfer) begin
      data_out    <= sh;
      data_ready  <= 1'b1;
      overrun_err <= data_ready && !rdy_clr;
      frame_err   <= fe_now;
      parity_err  <= pe_pend;
    end else if (rdy_clr) begin
      data_ready  <= 1'b0;
    end
  end

endmodule

module async_char_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rdy_clr,
  input logic [DATA_W-1:0] data_out,
  input logic              data_ready,
  input logic              overrun_err,
  input logic              frame_err,
  input logic              parity_err
);

  AST_RESET_QUIET: assert property (@(posedge clk) $past(rst) |-> (!data_ready && !overrun_err && !frame_err && !parity_err && data_out == '0)); // R1

  AST_READY_HOLDS: assert property (@(posedge clk) disable iff (rst) (data_ready && !rdy_clr) |=> data_ready); // R8

  AST_OVR_NEEDS_READY: assert property (@(posedge clk) disable iff (rst) $rose(overrun_err) |-> $past(data_ready)); // R9

  AST_FLAGS_ON_XFER: assert property (@(posedge clk) disable iff (rst) (!$stable(frame_err) || !$stable(parity_err) || !$stable(data_out)) |-> data_ready); // R7

endmodule

bind async_char_rx async_char_rx_chk #(.DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst(rst), .rdy_clr(rdy_clr), .data_out(data_out), .data_ready(data_ready),
  .overrun_err(overrun_err), .frame_err(frame_err), .parity_err(parity_err)
);

// File: tb/test_async_char_rx.sv
module test_async_char_rx;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_in = 1'b1;
  logic       cfg_load = 1'b0;
  logic [1:0] cfg_len = 2'd3;
  logic       cfg_par_off = 1'b1;
  logic       cfg_par_even = 1'b0;
  logic       cfg_two_stop = 1'b0;
  logic       rdy_clr = 1'b0;
  logic [7:0] data_out;
  logic       data_ready, overrun_err, frame_err, parity_err;

  int checks = 0;
  int failures = 0;
  logic rdy_mid;

  always #2 clk = ~clk;

  async_char_rx i_async_char_rx (
    .clk(clk), .rst(rst), .rx_in(rx_in), .cfg_load(cfg_load), .cfg_len(cfg_len),
    .cfg_par_off(cfg_par_off), .cfg_par_even(cfg_par_even), .cfg_two_stop(cfg_two_stop),
    .rdy_clr(rdy_clr), .data_out(data_out), .data_ready(data_ready),
    .overrun_err(overrun_err), .frame_err(frame_err), .parity_err(parity_err)
  );

  // {len[24:23], par_off[22], even[21], two[20], bad_par[19], bad_stop[18], tx[17:10], exp[9:2], pe[1], fe[0]}
  localparam logic [24:0] TBL [8] = '{
    {2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 8'hA5, 1'b0, 1'b0},
    {2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'hB6, 8'h16, 1'b0, 1'b0},
    {2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h2B, 8'h2B, 1'b0, 1'b0},
    {2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h55, 8'h55, 1'b0, 1'b0},
    {2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'hC3, 8'hC3, 1'b1, 1'b0},
    {2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h3C, 8'h3C, 1'b0, 1'b1},
    {2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h0A, 8'h0A, 1'b0, 1'b0},
    {2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h7F, 8'h7F, 1'b0, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive_bit(input logic v);
    rx_in = v;
    repeat (16) @(negedge clk);
  endtask

  task automatic load_cfg(input logic [1:0] len, input logic off, input logic even, input logic two);
    cfg_len = len; cfg_par_off = off; cfg_par_even = even; cfg_two_stop = two;
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic send(input logic [7:0] d, input int nb, input logic par_on, input logic even,
                      input logic badp, input logic bads, input logic two, input logic clr_x);
    logic [7:0] m;
    logic p;
    m = 8'hFF >> (8 - nb);
    p = even ? ^(d & m) : ~^(d & m);
    if (badp) p = ~p;
    drive_bit(1'b0);
    for (int i = 0; i < nb; i++) drive_bit(d[i]);
    if (par_on) drive_bit(p);
    if (two) begin
      drive_bit(1'b1);
      rdy_mid = data_ready;
    end
    for (int c = 0; c < 16; c++) begin
      rx_in = bads ? (c < 10 ? 1'b0 : 1'b1) : 1'b1;
      rdy_clr = clr_x && (c == 7);
      @(negedge clk);
    end
    rdy_clr = 1'b0;
    rx_in = 1'b1;
  endtask

  task automatic pulse_clr();
    rdy_clr = 1'b1;
    @(negedge clk);
    rdy_clr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset data_out", data_out, 0);
    chk("R1 reset data_ready", data_ready, 0);
    chk("R1 reset flags", {overrun_err, frame_err, parity_err}, 0);

    for (int i = 0; i < 8; i++) begin
      logic [24:0] v;
      v = TBL[i];
      load_cfg(v[24:23], v[22], v[21], v[20]);
      rdy_mid = 1'bx;
      send(v[17:10], 5 + int'(v[24:23]), !v[22], v[21], v[19], v[18], v[20], 1'b0);
      chk($sformatf("R3 vec%0d data_out", i), data_out, v[9:2]);
      chk($sformatf("R4 vec%0d parity_err", i), parity_err, v[1]);
      chk($sformatf("R5 vec%0d frame_err", i), frame_err, v[0]);
      chk($sformatf("R7 vec%0d data_ready", i), data_ready, 1);
      chk($sformatf("R9 vec%0d overrun_err", i), overrun_err, 0);
      if (v[20]) chk($sformatf("R5 vec%0d ready late with two stops", i), rdy_mid, 0);
      pulse_clr();
      chk($sformatf("R8 vec%0d ready cleared", i), data_ready, 0);
      chk($sformatf("R7 vec%0d flags held", i), {parity_err, frame_err}, {v[1], v[0]});
    end

    // R6: inputs changed without the strobe have no effect
    load_cfg(2'd3, 1'b1, 1'b0, 1'b0);
    cfg_len = 2'd0; cfg_par_off = 1'b0; cfg_par_even = 1'b1; cfg_two_stop = 1'b1;
    send(8'hE7, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R6 unloaded cfg data", data_out, 8'hE7);
    chk("R6 unloaded cfg ready", data_ready, 1);
    chk("R6 unloaded cfg parity", parity_err, 0);
    pulse_clr();

    // R2: seven clocks low is a glitch, then a real frame is received
    rx_in = 1'b0;
    repeat (7) @(negedge clk);
    rx_in = 1'b1;
    repeat (40) @(negedge clk);
    chk("R2 short low ignored", data_ready, 0);
    chk("R2 short low leaves data", data_out, 8'hE7);
    send(8'h81, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R2 frame after glitch", data_out, 8'h81);

    // R9: unread character overrun, then clear in the transfer cycle
    send(8'h42, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R9 overrun set", overrun_err, 1);
    chk("R9 overrun data", data_out, 8'h42);
    send(8'h24, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R9 same-cycle clear no overrun", overrun_err, 0);
    chk("R9 same-cycle clear ready", data_ready, 1);
    chk("R9 same-cycle clear data", data_out, 8'h24);
    pulse_clr();

    // R1: reset in the middle of a frame
    rx_in = 1'b0;
    repeat (20) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rx_in = 1'b1;
    rst = 1'b0;
    @(negedge clk);
    chk("R1 mid-frame reset ready", data_ready, 0);
    chk("R1 mid-frame reset data", data_out, 0);
    send(8'h5A, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R1 default format after reset", data_out, 8'h5A);
    chk("R1 default format no errors", {parity_err, frame_err, overrun_err}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule